// File: doc/BRIEF.md
# Platform Power-State Sequencer

This block steps a host platform through its four ACPI power levels: mechanical off (G3), soft off (S5), suspend-to-RAM (S3) and working (S0). It never jumps straight from one level to another. Every move passes through a dedicated transition state, and that state runs a fixed order of rail enables, handshake edges and timed waits. The sequencer watches three power-good inputs and the two active-low sleep requests from the chipset. It drives the regulator enables, the deep-power-ok, resume-reset and PWROK handshakes, a CPU throttle line and a touchpad enable. The current state is exposed as a 4-bit code.

Every wait is measured in milliseconds. The milliseconds come from one shared counter, and that counter is advanced by a prescaler of `CLK_PER_MS` cycles, so a small prescale shortens every delay in proportion. A wait for a rail that runs past its timeout aborts the step. The block then drops the chipset handshakes and falls back to the level it came from. A rail that fails while the platform is resting in S3 or S0 also forces the chipset down.

The block is used as the power-control core of an embedded controller. Its inputs come from already-synchronised board signals, and its outputs go straight to the regulators and the chipset.

Top module: `pwr_seq_top`

## Requirements
- R1: After reset, the state code is 0 and every sequenced output is low: dpwrOk, resumeRstN, pwrOk, coreEn, s0RailEn, ddrEn, throttleOut and touchpadEn.
- R2: susAckN always equals susWarnN.
- R3: In G3 (code 0), exitReq moves the block to G3→S5 (code 4). That state waits BOOT_MS, then raises dpwrOk and resumeRstN together. It waits SETTLE_MS more, then enters S5 (code 1). Each wait of N ms lasts N·CLK_PER_MS+1 cycles.
- R4: In S5 with slpS5N low, IDLE_MS without a change on any monitored input (powerGood, slpS3N, slpS5N, susWarnN, throttleReq) leads to S5→G3 (code 9). That state lasts one cycle, drops dpwrOk and resumeRstN, and enters G3. Any change on a monitored input restarts the idle count.
- R5: In S5, a high slpS5N enters S5→S3 (code 5). That state waits for powerGood bit 0 (always-on) and then sets ddrEn. It next waits for bits 0 and 1 (DDR) together, then sets touchpadEn and enters S3 (code 2).
- R6: If either wait in S5→S3 exceeds TIMEOUT_MS, the block clears dpwrOk, resumeRstN and ddrEn and returns to S5.
- R7: In S3, a high slpS3N enters S3→S0 (code 6). Otherwise a low slpS5N enters S3→S5 (code 8), which lasts one cycle, clears ddrEn and touchpadEn, and enters S5.
- R8: S3→S0 sets s0RailEn on entry. It waits for powerGood bits 0, 1 and 2 (non-core), then sets coreEn. After CORE_MS more it sets pwrOk, loads throttleOut from throttleReq and enters S0 (code 3). In S0, throttleOut follows throttleReq with one cycle of delay.
- R9: If the non-core wait in S3→S0 exceeds TIMEOUT_MS, the block clears s0RailEn, dpwrOk and resumeRstN and returns to S3.
- R10: A low slpS3N in S0 enters S0→S3 (code 7) and clears pwrOk on entry. GAP_CYC cycles later, coreEn and throttleOut drop. One cycle after that, s0RailEn drops and the block enters S3.
- R11: A rail missing in S3 (bit 0 or bit 1) or in S0 (bit 0, 1 or 2) clears dpwrOk and resumeRstN at once. The block then moves to S3→S5 or S0→S3 respectively.
- R12: The state code never exceeds 9, and it reads 0 (G3) only while dpwrOk is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| powerGood | input | 3 | Power-good: bit 0 always-on, bit 1 DDR, bit 2 non-core |
| slpS3N | input | 1 | Chipset S3 sleep request, active low |
| slpS5N | input | 1 | Chipset S5 sleep request, active low |
| susWarnN | input | 1 | Suspend warning from chipset, active low |
| exitReq | input | 1 | Request to leave G3 |
| throttleReq | input | 1 | CPU throttle request |
| dpwrOk | output | 1 | Deep-power-ok to chipset |
| resumeRstN | output | 1 | Resume reset to chipset, active low |
| pwrOk | output | 1 | Platform PWROK |
| coreEn | output | 1 | CPU/graphics core regulator enable |
| s0RailEn | output | 1 | S0 rail and wireless enable |
| ddrEn | output | 1 | Memory rail enable |
| throttleOut | output | 1 | Throttle line to CPU |
| touchpadEn | output | 1 | Touchpad power enable |
| susAckN | output | 1 | Suspend acknowledge, active low |
| stateCode | output | 4 | Current state code |

## Verification
The assertions assume that the chipset and the regulators behave like real parts: power-good inputs come up only after their enables, and the sleep requests change only between sequencing steps. The stimulus keeps to this. It raises power-good bits only while the matching enable is high, except in the deliberate timeout and rail-loss cases. It changes slpS3N and slpS5N only at states where their effect has been worked out. The timing sweeps use a prescale of four cycles per millisecond. Every dwell is therefore an exact cycle count that the bench derives from the millisecond parameters.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  // Power-good vector layout
  localparam int PG_W       = 3;
  localparam int PG_ALWAYS  = 0;
  localparam int PG_DDR     = 1;
  localparam int PG_NONCORE = 2;

  // Monitored input vector width for idle detection
  localparam int MON_W = PG_W + 4;

  typedef enum logic [3:0] {
    ST_G3   = 4'd0,
    ST_S5   = 4'd1,
    ST_S3   = 4'd2,
    ST_S0   = 4'd3,
    ST_G3S5 = 4'd4,
    ST_S5S3 = 4'd5,
    ST_S3S0 = 4'd6,
    ST_S0S3 = 4'd7,
    ST_S3S5 = 4'd8,
    ST_S5G3 = 4'd9
  } pwrState_t;

  // Output register bank positions
  localparam int O_DPWR  = 0;
  localparam int O_RSM   = 1;
  localparam int O_PWROK = 2;
  localparam int O_CORE  = 3;
  localparam int O_S0    = 4;
  localparam int O_DDR   = 5;
  localparam int O_THR   = 6;
  localparam int O_TOUCH = 7;
  localparam int OUT_N   = 8;

  typedef struct packed {
    logic timerClr;
    logic dpwrSet;
    logic dpwrClr;
    logic ddrSet;
    logic ddrClr;
    logic s0Set;
    logic s0Clr;
    logic coreSet;
    logic coreClr;
    logic pwrOkSet;
    logic pwrOkClr;
    logic throttleLoad;
    logic throttleClr;
    logic touchSet;
    logic touchClr;
  } seqStrobe_t;

endpackage

// File: rtl/pwr_seq_dp.sv
module pwr_seq_dp
  import pwr_seq_pkg::*;
#(
  parameter int CLK_PER_MS = 1000,
  parameter int MS_W       = 16,
  parameter int SUB_W      = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [MON_W-1:0]  monVec,
  input  logic              throttleReq,
  output logic [MS_W-1:0]   msCount,
  output logic [SUB_W-1:0]  subCount,
  output logic              inChanged,
  output logic [OUT_N-1:0]  outQ
);

  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(CLK_PER_MS - 1);

  logic [MON_W-1:0] prevMon;
  logic [OUT_N-1:0] setV;
  logic [OUT_N-1:0] clrV;

  assign inChanged = (monVec != prevMon);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevMon <= '0;
    else       prevMon <= monVec;
  end

  // Shared millisecond timer with cycle prescaler; ms count saturates
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      subCount <= '0;
      msCount  <= '0;
    end else if (strobe.timerClr) begin
      subCount <= '0;
      msCount  <= '0;
    end else if (subCount == SUB_LAST) begin
      subCount <= '0;
      if (msCount != '1) msCount <= msCount + 1'b1;
    end else begin
      subCount <= subCount + 1'b1;
    end
  end

  always_comb begin
    setV = '0;
    clrV = '0;
    setV[O_DPWR]  = strobe.dpwrSet;
    clrV[O_DPWR]  = strobe.dpwrClr;
    setV[O_RSM]   = strobe.dpwrSet;
    clrV[O_RSM]   = strobe.dpwrClr;
    setV[O_PWROK] = strobe.pwrOkSet;
    clrV[O_PWROK] = strobe.pwrOkClr;
    setV[O_CORE]  = strobe.coreSet;
    clrV[O_CORE]  = strobe.coreClr;
    setV[O_S0]    = strobe.s0Set;
    clrV[O_S0]    = strobe.s0Clr;
    setV[O_DDR]   = strobe.ddrSet;
    clrV[O_DDR]   = strobe.ddrClr;
    setV[O_THR]   = strobe.throttleLoad & throttleReq;
    clrV[O_THR]   = strobe.throttleClr | (strobe.throttleLoad & ~throttleReq);
    setV[O_TOUCH] = strobe.touchSet;
    clrV[O_TOUCH] = strobe.touchClr;
  end

  // One set/clear flop per sequenced output; clear wins
  for (genvar i = 0; i < OUT_N; i++) begin : g_outReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        outQ[i] <= 1'b0;
      else if (clrV[i]) outQ[i] <= 1'b0;
      else if (setV[i]) outQ[i] <= 1'b1;
    end
  end

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int BOOT_MS    = 10,
  parameter int SETTLE_MS  = 5,
  parameter int IDLE_MS    = 10000,
  parameter int TIMEOUT_MS = 1000,
  parameter int CORE_MS    = 99,
  parameter int GAP_CYC    = 4,
  parameter int MS_W       = 16,
  parameter int SUB_W      = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PG_W-1:0]  powerGood,
  input  logic             slpS3N,
  input  logic             slpS5N,
  input  logic             exitReq,
  input  logic [MS_W-1:0]  msCount,
  input  logic [SUB_W-1:0] subCount,
  input  logic             inChanged,
  output seqStrobe_t       strobe,
  output logic [3:0]       stateCode
);

  pwrState_t state, nxt;
  logic      phase, phaseNxt, advance;
  logic      s3Good, s0Good, timedOut;

  assign s3Good    = powerGood[PG_ALWAYS] & powerGood[PG_DDR];
  assign s0Good    = s3Good & powerGood[PG_NONCORE];
  assign timedOut  = (msCount >= MS_W'(TIMEOUT_MS));
  assign stateCode = state;

  always_comb begin
    nxt     = state;
    advance = 1'b0;
    strobe  = '0;
    unique case (state)
      ST_G3: if (exitReq) nxt = ST_G3S5;
      ST_G3S5:
        if (!phase) begin
          if (msCount >= MS_W'(BOOT_MS)) begin
            strobe.dpwrSet = 1'b1;
            advance        = 1'b1;
          end
        end else if (msCount >= MS_W'(SETTLE_MS)) nxt = ST_S5;
      ST_S5:
        if (slpS5N)                           nxt = ST_S5S3;
        else if (msCount >= MS_W'(IDLE_MS))   nxt = ST_S5G3;
      ST_S5G3: begin
        strobe.dpwrClr = 1'b1;
        nxt            = ST_G3;
      end
      ST_S5S3:
        if (!phase && powerGood[PG_ALWAYS]) begin
          strobe.ddrSet = 1'b1;
          advance       = 1'b1;
        end else if (phase && s3Good) begin
          strobe.touchSet = 1'b1;
          nxt             = ST_S3;
        end else if (timedOut) begin
          strobe.dpwrClr = 1'b1;
          strobe.ddrClr  = 1'b1;
          nxt            = ST_S5;
        end
      ST_S3:
        if (!s3Good) begin
          strobe.dpwrClr = 1'b1;
          nxt            = ST_S3S5;
        end else if (slpS3N) begin
          strobe.s0Set = 1'b1;
          nxt          = ST_S3S0;
        end else if (!slpS5N) nxt = ST_S3S5;
      ST_S3S0:
        if (!phase) begin
          if (s0Good) begin
            strobe.coreSet = 1'b1;
            advance        = 1'b1;
          end else if (timedOut) begin
            strobe.dpwrClr = 1'b1;
            strobe.s0Clr   = 1'b1;
            nxt            = ST_S3;
          end
        end else if (msCount >= MS_W'(CORE_MS)) begin
          strobe.pwrOkSet     = 1'b1;
          strobe.throttleLoad = 1'b1;
          nxt                 = ST_S0;
        end
      ST_S0: begin
        strobe.throttleLoad = 1'b1;
        if (!s0Good) begin
          strobe.dpwrClr  = 1'b1;
          strobe.pwrOkClr = 1'b1;
          nxt             = ST_S0S3;
        end else if (!slpS3N) begin
          strobe.pwrOkClr = 1'b1;
          nxt             = ST_S0S3;
        end
      end
      ST_S0S3:
        if (!phase) begin
          if ((msCount != '0) || (subCount >= SUB_W'(GAP_CYC))) begin
            strobe.coreClr     = 1'b1;
            strobe.throttleClr = 1'b1;
            advance            = 1'b1;
          end
        end else begin
          strobe.s0Clr = 1'b1;
          nxt          = ST_S3;
        end
      ST_S3S5: begin
        strobe.touchClr = 1'b1;
        strobe.ddrClr   = 1'b1;
        nxt             = ST_S5;
      end
      default: nxt = ST_G3;
    endcase

    phaseNxt = (nxt != state) ? 1'b0 : (phase | advance);
    strobe.timerClr = advance | (nxt != state) | ((state == ST_S5) & inChanged);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_G3;
      phase <= 1'b0;
    end else begin
      state <= nxt;
      phase <= phaseNxt;
    end
  end

endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
  import pwr_seq_pkg::*;
#(
  parameter int CLK_PER_MS = 1000,
  parameter int BOOT_MS    = 10,
  parameter int SETTLE_MS  = 5,
  parameter int IDLE_MS    = 10000,
  parameter int TIMEOUT_MS = 1000,
  parameter int CORE_MS    = 99,
  parameter int GAP_CYC    = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PG_W-1:0] powerGood,
  input  logic            slpS3N,
  input  logic            slpS5N,
  input  logic            susWarnN,
  input  logic            exitReq,
  input  logic            throttleReq,
  output logic            dpwrOk,
  output logic            resumeRstN,
  output logic            pwrOk,
  output logic            coreEn,
  output logic            s0RailEn,
  output logic            ddrEn,
  output logic            throttleOut,
  output logic            touchpadEn,
  output logic            susAckN,
  output logic [3:0]      stateCode
);

  localparam int MAX_MS = (IDLE_MS > TIMEOUT_MS) ? IDLE_MS : TIMEOUT_MS;
  localparam int MS_W   = $clog2(MAX_MS + 1) + 1;
  localparam int SUB_W  = $clog2(CLK_PER_MS + 1);

  seqStrobe_t       strobe;
  logic [MS_W-1:0]  msCount;
  logic [SUB_W-1:0] subCount;
  logic             inChanged;
  logic [OUT_N-1:0] outQ;
  logic [MON_W-1:0] monVec;

  assign monVec  = {throttleReq, susWarnN, slpS5N, slpS3N, powerGood};
  assign susAckN = susWarnN;

  pwr_seq_ctrl #(
    .BOOT_MS(BOOT_MS), .SETTLE_MS(SETTLE_MS), .IDLE_MS(IDLE_MS),
    .TIMEOUT_MS(TIMEOUT_MS), .CORE_MS(CORE_MS), .GAP_CYC(GAP_CYC),
    .MS_W(MS_W), .SUB_W(SUB_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .powerGood(powerGood), .slpS3N(slpS3N),
    .slpS5N(slpS5N), .exitReq(exitReq), .msCount(msCount),
    .subCount(subCount), .inChanged(inChanged), .strobe(strobe),
    .stateCode(stateCode)
  );

  pwr_seq_dp #(
    .CLK_PER_MS(CLK_PER_MS), .MS_W(MS_W), .SUB_W(SUB_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .monVec(monVec),
    .throttleReq(throttleReq), .msCount(msCount), .subCount(subCount),
    .inChanged(inChanged), .outQ(outQ)
  );

  assign dpwrOk      = outQ[O_DPWR];
  assign resumeRstN  = outQ[O_RSM];
  assign pwrOk       = outQ[O_PWROK];
  assign coreEn      = outQ[O_CORE];
  assign s0RailEn    = outQ[O_S0];
  assign ddrEn       = outQ[O_DDR];
  assign throttleOut = outQ[O_THR];
  assign touchpadEn  = outQ[O_TOUCH];

endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       susWarnN,
  input logic       susAckN,
  input logic       dpwrOk,
  input logic       pwrOk,
  input logic       coreEn,
  input logic       s0RailEn,
  input logic       ddrEn,
  input logic [3:0] stateCode
);

  // R2
  ack_mirror_chk: assert property (@(posedge clk) disable iff (!rstN)
    susAckN == susWarnN);

  // R3
  dpwr_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dpwrOk) |-> stateCode == 4'd4);

  // R5
  ddr_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ddrEn) |-> stateCode == 4'd5);

  // R8
  pwrok_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwrOk) |-> stateCode == 4'd3);

  // R10
  pwrok_needs_rails_chk: assert property (@(posedge clk) disable iff (!rstN)
    pwrOk |-> (coreEn && s0RailEn));

  // R12
  state_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    stateCode <= 4'd9);

  // R12
  g3_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 4'd0) |-> !dpwrOk);

endmodule

bind pwr_seq_top pwr_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .susWarnN(susWarnN), .susAckN(susAckN),
  .dpwrOk(dpwrOk), .pwrOk(pwrOk), .coreEn(coreEn), .s0RailEn(s0RailEn),
  .ddrEn(ddrEn), .stateCode(stateCode)
);

// File: tb/pwr_seq_top_bench.sv
module pwr_seq_top_bench;

  localparam int CPM     = 4;
  localparam int BOOT    = 10;
  localparam int SETTLE  = 5;
  localparam int IDLE    = 2000;
  localparam int TMO     = 100;
  localparam int CORE    = 99;
  localparam int GAP     = 4;
  localparam int LIMIT   = 50000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] pg = 3'b000;
  logic       slpS3N = 1'b0, slpS5N = 1'b0, susWarnN = 1'b1;
  logic       exitReq = 1'b0, throttleReq = 1'b0;
  logic       dpwrOk, resumeRstN, pwrOk, coreEn, s0RailEn, ddrEn;
  logic       throttleOut, touchpadEn, susAckN;
  logic [3:0] stateCode;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  pwr_seq_top #(
    .CLK_PER_MS(CPM), .BOOT_MS(BOOT), .SETTLE_MS(SETTLE), .IDLE_MS(IDLE),
    .TIMEOUT_MS(TMO), .CORE_MS(CORE), .GAP_CYC(GAP)
  ) u_pwr_seq_top (
    .clk(clk), .rstN(rstN), .powerGood(pg), .slpS3N(slpS3N),
    .slpS5N(slpS5N), .susWarnN(susWarnN), .exitReq(exitReq),
    .throttleReq(throttleReq), .dpwrOk(dpwrOk), .resumeRstN(resumeRstN),
    .pwrOk(pwrOk), .coreEn(coreEn), .s0RailEn(s0RailEn), .ddrEn(ddrEn),
    .throttleOut(throttleOut), .touchpadEn(touchpadEn), .susAckN(susAckN),
    .stateCode(stateCode)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic waitState(input string req, input int code);
    int n = 0;
    while (int'(stateCode) != code && n < LIMIT) begin
      @(negedge clk);
      n++;
    end
    if (n >= LIMIT) chk(req, int'(stateCode), code);
  endtask

  // Counts negedges spent in the current state; hi counts a selected output high
  task automatic dwell(input int sel, output int total, output int hi);
    int code = int'(stateCode);
    total = 0;
    hi = 0;
    do begin
      total++;
      case (sel)
        0: hi += int'(dpwrOk);
        1: hi += int'(ddrEn);
        default: hi += int'(coreEn);
      endcase
      @(negedge clk);
    end while (int'(stateCode) == code && total < LIMIT);
  endtask

  task automatic powerUp();
    waitState("R4 idle to G3", 0);
    exitReq = 1'b1;
    @(negedge clk);
    exitReq = 1'b0;
    waitState("R3 reach S5", 1);
    slpS5N = 1'b1;
    waitState("R5 reach S3", 2);
  endtask

  initial begin
    wait (cyc >= 190000);
    errors++;
    checks++;
    $display("FAIL watchdog (all requirements): actual %0d expected 0", cyc);
    finishRun();
  end

  initial begin
    int tot, hi;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 state", int'(stateCode), 0);
    chk("R1 outputs", int'({dpwrOk, resumeRstN, pwrOk, coreEn, s0RailEn,
                             ddrEn, throttleOut, touchpadEn}), 0);

    // R2 acknowledge mirror
    for (int i = 0; i < 4; i++) begin
      susWarnN = i[0];
      #1;
      chk("R2 mirror", int'(susAckN), i % 2);
    end
    susWarnN = 1'b1;
    @(negedge clk);

    // R3 boot timing
    exitReq = 1'b1;
    @(negedge clk);
    exitReq = 1'b0;
    chk("R3 enter G3S5", int'(stateCode), 4);
    dwell(0, tot, hi);
    chk("R3 dpwrOk low span", tot - hi, BOOT * CPM + 1);
    chk("R3 dpwrOk high span", hi, SETTLE * CPM + 1);
    chk("R3 S5 reached", int'(stateCode), 1);
    chk("R3 resumeRstN", int'(resumeRstN), 1);

    // R4 idle timeout back to G3
    dwell(0, tot, hi);
    chk("R4 S5 idle span", tot, IDLE * CPM + 1);
    chk("R4 S5G3 state", int'(stateCode), 9);
    @(negedge clk);
    chk("R4 G3 reached", int'(stateCode), 0);
    chk("R4 dpwr dropped", int'({dpwrOk, resumeRstN}), 0);

    // R4 input change restarts idle count
    exitReq = 1'b1;
    @(negedge clk);
    exitReq = 1'b0;
    waitState("R4 reach S5", 1);
    repeat (100) @(negedge clk);
    throttleReq = 1'b1;
    @(negedge clk);
    dwell(0, tot, hi);
    chk("R4 restarted idle span", tot, IDLE * CPM + 1);
    waitState("R4 back to G3", 0);
    throttleReq = 1'b0;

    // R5 / R6 S5S3 with DDR never good
    exitReq = 1'b1;
    @(negedge clk);
    exitReq = 1'b0;
    waitState("R6 reach S5", 1);
    slpS5N = 1'b1;
    @(negedge clk);
    repeat (10) @(negedge clk);
    chk("R5 wait always-on state", int'(stateCode), 5);
    chk("R5 ddr held off", int'(ddrEn), 0);
    pg = 3'b001;
    @(negedge clk);
    chk("R5 ddr on after always-on", int'(ddrEn), 1);
    slpS5N = 1'b0;
    dwell(1, tot, hi);
    chk("R6 ddr wait span", tot, TMO * CPM + 1);
    chk("R6 back to S5", int'(stateCode), 1);
    chk("R6 shutdown outputs", int'({dpwrOk, resumeRstN, ddrEn}), 0);

    // R5 clean S5S3
    pg = 3'b011;
    waitState("R6 idle to G3", 0);
    exitReq = 1'b1;
    @(negedge clk);
    exitReq = 1'b0;
    waitState("R5 reach S5", 1);
    slpS5N = 1'b1;
    @(negedge clk);
    dwell(1, tot, hi);
    chk("R5 S5S3 span", tot, 2);
    chk("R5 S3 reached", int'(stateCode), 2);
    chk("R5 ddr and touch", int'({ddrEn, touchpadEn, dpwrOk}), 7);

    // R7 S3 hold
    repeat (20) @(negedge clk);
    chk("R7 S3 hold", int'(stateCode), 2);

    // R8 S3S0 success and throttle follow
    pg = 3'b111;
    throttleReq = 1'b1;
    slpS3N = 1'b1;
    @(negedge clk);
    chk("R8 s0 rail on entry", int'(s0RailEn), 1);
    dwell(2, tot, hi);
    chk("R8 S3S0 span", tot, CORE * CPM + 2);
    chk("R8 core high span", hi, CORE * CPM + 1);
    chk("R8 S0 reached", int'(stateCode), 3);
    chk("R8 pwrOk and throttle", int'({pwrOk, throttleOut}), 3);
    throttleReq = 1'b0;
    @(negedge clk);
    chk("R8 throttle follow low", int'(throttleOut), 0);
    throttleReq = 1'b1;
    @(negedge clk);
    chk("R8 throttle follow high", int'(throttleOut), 1);

    // R10 S0S3 order
    slpS3N = 1'b0;
    @(negedge clk);
    chk("R10 enter S0S3", int'(stateCode), 7);
    chk("R10 pwrOk first", int'({pwrOk, coreEn, s0RailEn}), 3);
    dwell(2, tot, hi);
    chk("R10 core hold span", hi, GAP + 1);
    chk("R10 S0S3 span", tot, GAP + 2);
    chk("R10 S3 outputs", int'({coreEn, throttleOut, s0RailEn, pwrOk}), 0);

    // R11 rail loss in S0
    slpS3N = 1'b1;
    waitState("R11 reach S0", 3);
    pg = 3'b011;
    slpS3N = 1'b0;
    @(negedge clk);
    chk("R11 S0 loss state", int'(stateCode), 7);
    chk("R11 S0 loss shutdown", int'({dpwrOk, resumeRstN, pwrOk}), 0);
    waitState("R11 back to S3", 2);

    // R7 normal S3 to S5
    slpS5N = 1'b0;
    @(negedge clk);
    chk("R7 S3S5 state", int'(stateCode), 8);
    @(negedge clk);
    chk("R7 S5 reached", int'(stateCode), 1);
    chk("R7 ddr and touch off", int'({ddrEn, touchpadEn}), 0);

    // R11 rail loss in S3
    powerUp();
    chk("R11 dpwr up in S3", int'(dpwrOk), 1);
    pg = 3'b001;
    slpS5N = 1'b0;
    @(negedge clk);
    chk("R11 S3 loss state", int'(stateCode), 8);
    chk("R11 S3 loss shutdown", int'({dpwrOk, resumeRstN}), 0);
    @(negedge clk);
    chk("R11 S5 outputs", int'({stateCode, ddrEn, touchpadEn}), 4);

    // R9 S3S0 timeout
    pg = 3'b011;
    slpS5N = 1'b1;
    waitState("R9 reach S3", 2);
    slpS3N = 1'b1;
    @(negedge clk);
    slpS3N = 1'b0;
    dwell(2, tot, hi);
    chk("R9 non-core wait span", tot, TMO * CPM + 1);
    chk("R9 back to S3", int'(stateCode), 2);
    chk("R9 rails off", int'({s0RailEn, coreEn, dpwrOk}), 0);

    finishRun();
  end

endmodule